// File: doc/BRIEF.md
# Serial Link Bit Error Tester

This block is a built-in test for a serial link, with one half on each end. The transmit half swaps the normal parallel data for a pseudo-random pattern at the point where words enter the line encoder. The receive half regenerates the same pattern from what arrives and compares every bit. It then reports on an active-low result pin: high means no error has been seen, low means at least one bit was wrong. The link's 8b/10b coding, scrambling, serialisation and line drivers sit outside the block and carry the pattern unchanged.

Two test paths exist, a main link and a sub link, and only one of them can be under test at any time. On the main path a latch-enable input picks the result style. With latch-enable high the error is held until latch-enable goes low. With latch-enable low the pin shows the compare result of each word. On the sub path the error is always held, and only a full reset releases it. A configuration input forces the main path whatever the path-select input says.

The receiver does not need to know the pattern phase. It seeds its generator from the incoming words and reports nothing until it has seen a run of clean words. The generator is held off until test mode is active, so the checker is always armed first.

Top module: `link_bert`

## Requirements
- R1: When the generator is not running, `tx_data` equals `norm_data` in the same cycle.
- R2: The generator emits PRBS-7 (x^7 + x^6 + 1). Each output bit is the XOR of the bits produced 7 and 6 steps earlier. The 7 bits before the first output bit are all ones. Eight bits form one word, earliest bit in bit 7. Every start of the generator restarts from that seed.
- R3: Once test mode is active, the checker uses the first received word as its seed. `chk_locked` rises after the 16th following word in a row that matches the prediction, and not before.
- R4: Before lock no mismatch pulls `result_n` low. A mismatch during the hunt restarts the run count.
- R5: In main mode with `latch_en` low, `result_n` is low in exactly the cycle after each locked word with any wrong bit, and high after a clean word.
- R6: In main mode with `latch_en` high, an error holds `result_n` low for as long as `latch_en` stays high. Dropping `latch_en` releases the pin one cycle later.
- R7: In sub mode an error always holds `result_n` low. `latch_en` has no effect. The hold survives leaving and re-entering test mode, and only `rst_n` clears it.
- R8: `mode_main` and `mode_sub` are never high together. A direct change of path passes through one cycle with both low.
- R9: With `main_force` high, test mode runs on the main path whatever `link_sel` is.
- R10: While test mode is inactive, `result_n` is high and the main-path hold is cleared.
- R11: `gen_en` is ignored until test mode is active, which arms the checker before the pattern starts.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| test_en | input | 1 | Requests link test mode |
| link_sel | input | 1 | Path select: 0 main link, 1 sub link |
| main_force | input | 1 | Forces the main path while high |
| latch_en | input | 1 | Main path: 1 held result, 0 live result |
| gen_en | input | 1 | Lets the pattern generator run in test mode |
| norm_data | input | 8 | Normal transmit word |
| tx_data | output | 8 | Word to the line encoder |
| rx_data | input | 8 | Word from the line decoder |
| result_n | output | 1 | Test result, low on bit error |
| chk_locked | output | 1 | Checker has synchronised to the pattern |
| mode_main | output | 1 | Main-link test active |
| mode_sub | output | 1 | Sub-link test active |

## Verification
A checker seeded or stepped wrongly never reaches `chk_locked`, or shows a `result_n` pulse on every word right after lock. Either one is visible within 17 words of entering test mode. A bad generator state shows up on `tx_data` in the first word after test mode starts. A wrong latching policy shows only once an error is injected. It then appears one cycle after the bad word, or one cycle after a `latch_en` edge. On the sub path it may appear only after the mode is left and re-entered. The bench therefore injects single-bit faults at every bit position, and it toggles `latch_en` and the mode while an error is held.

// File: rtl/bert_pkg.sv
`timescale 1ns/1ps
package bert_pkg;
  typedef enum logic [1:0] {
    MODE_IDLE = 2'd0,
    MODE_MAIN = 2'd1,
    MODE_SUB  = 2'd2
  } bert_mode_e;

  typedef enum logic [1:0] {
    CHK_OFF  = 2'd0,
    CHK_SEED = 2'd1,
    CHK_HUNT = 2'd2,
    CHK_LOCK = 2'd3
  } chk_state_e;

  localparam int unsigned BERT_DATA_W   = 8;
  localparam int unsigned BERT_LFSR_W   = 7;
  localparam int unsigned BERT_TAP_HI   = 7;
  localparam int unsigned BERT_TAP_LO   = 6;
  localparam int unsigned BERT_LOCK_RUN = 16;
endpackage

// File: rtl/bert_prbs_step.sv
`timescale 1ns/1ps
// Advances a Fibonacci LFSR by DW bits in one cycle; first bit lands in the MSB.
module bert_prbs_step #(
  parameter int unsigned DW = 8,
  parameter int unsigned LW = 7,
  parameter int unsigned TA = 7,
  parameter int unsigned TB = 6
) (
  input  logic [LW-1:0] state_i,
  output logic [DW-1:0] word_o,
  output logic [LW-1:0] state_o
);
  logic [DW:0][LW-1:0] chain;
  assign chain[0] = state_i;

  for (genvar g = 0; g < DW; g++) begin : g_bit
    logic fb;
    assign fb            = chain[g][TA-1] ^ chain[g][TB-1];
    assign word_o[DW-1-g] = fb;
    assign chain[g+1]    = {chain[g][LW-2:0], fb};
  end

  assign state_o = chain[DW];
endmodule

// File: rtl/bert_mode_arb.sv
`timescale 1ns/1ps
module bert_mode_arb
  import bert_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       test_en,
  input  logic       link_sel,
  input  logic       main_force,
  output bert_mode_e mode_q,
  output logic       main_o,
  output logic       sub_o
);
  logic       eff_sub;
  bert_mode_e req;
  bert_mode_e mode_d;

  assign eff_sub = link_sel & ~main_force;

  always_comb begin
    if (!test_en)     req = MODE_IDLE;
    else if (eff_sub) req = MODE_SUB;
    else              req = MODE_MAIN;
  end

  // A path change never goes straight across: one idle cycle in between.
  always_comb begin
    if (mode_q != MODE_IDLE && req != MODE_IDLE && req != mode_q) mode_d = MODE_IDLE;
    else                                                          mode_d = req;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= MODE_IDLE;
    else        mode_q <= mode_d;
  end

  assign main_o = (mode_q == MODE_MAIN);
  assign sub_o  = (mode_q == MODE_SUB);
endmodule

// File: rtl/bert_pattern_gen.sv
`timescale 1ns/1ps
module bert_pattern_gen #(
  parameter int unsigned DW = 8,
  parameter int unsigned LW = 7,
  parameter int unsigned TA = 7,
  parameter int unsigned TB = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic [DW-1:0] norm_data,
  output logic [DW-1:0] tx_data
);
  localparam logic [LW-1:0] SEED = '1;

  logic [LW-1:0] state_q;
  logic [LW-1:0] state_nx;
  logic [DW-1:0] word;

  bert_prbs_step #(.DW(DW), .LW(LW), .TA(TA), .TB(TB)) u_step (
    .state_i (state_q),
    .word_o  (word),
    .state_o (state_nx)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   state_q <= SEED;
    else if (run) state_q <= state_nx;
    else          state_q <= SEED;
  end

  assign tx_data = run ? word : norm_data;
endmodule

// File: rtl/bert_pattern_chk.sv
`timescale 1ns/1ps
module bert_pattern_chk
  import bert_pkg::*;
#(
  parameter int unsigned DW       = 8,
  parameter int unsigned LW       = 7,
  parameter int unsigned TA       = 7,
  parameter int unsigned TB       = 6,
  parameter int unsigned LOCK_RUN = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          active,
  input  logic [DW-1:0] rx_data,
  output logic          locked,
  output logic          err_now
);
  localparam int unsigned CW = $clog2(LOCK_RUN + 1);
  localparam logic [CW-1:0] RUN_LAST = CW'(LOCK_RUN);

  chk_state_e    st_q;
  logic [LW-1:0] state_q;
  logic [CW-1:0] run_q;
  logic [DW-1:0] pred;
  logic [LW-1:0] pred_state;
  logic          match;
  logic [CW-1:0] run_inc;

  bert_prbs_step #(.DW(DW), .LW(LW), .TA(TA), .TB(TB)) u_step (
    .state_i (state_q),
    .word_o  (pred),
    .state_o (pred_state)
  );

  assign match   = (rx_data == pred);
  assign run_inc = run_q + 1'b1;

  // After DW >= LW steps the LFSR state equals the last LW bits of the word.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= CHK_OFF;
      state_q <= '0;
      run_q   <= '0;
    end else if (!active) begin
      st_q    <= CHK_OFF;
      state_q <= '0;
      run_q   <= '0;
    end else begin
      unique case (st_q)
        CHK_OFF, CHK_SEED: begin
          state_q <= rx_data[LW-1:0];
          run_q   <= '0;
          st_q    <= CHK_HUNT;
        end
        CHK_HUNT: begin
          state_q <= rx_data[LW-1:0];
          if (!match) begin
            run_q <= '0;
          end else if (run_inc == RUN_LAST) begin
            run_q <= '0;
            st_q  <= CHK_LOCK;
          end else begin
            run_q <= run_inc;
          end
        end
        CHK_LOCK: begin
          state_q <= pred_state;
        end
        default: st_q <= CHK_OFF;
      endcase
    end
  end

  assign locked  = (st_q == CHK_LOCK);
  assign err_now = active & locked & ~match;
endmodule

// File: rtl/bert_result.sv
`timescale 1ns/1ps
module bert_result
  import bert_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  bert_mode_e mode,
  input  logic       latch_en,
  input  logic       err_now,
  output logic       result_n
);
  logic main_hold_q;
  logic sub_hold_q;
  logic main_hold_d;
  logic sub_hold_d;
  logic fail_d;

  assign main_hold_d = (mode == MODE_MAIN && latch_en) ? (main_hold_q | err_now) : 1'b0;
  assign sub_hold_d  = sub_hold_q | (mode == MODE_SUB && err_now);

  always_comb begin
    unique case (mode)
      MODE_MAIN: fail_d = latch_en ? (main_hold_q | err_now) : err_now;
      MODE_SUB:  fail_d = sub_hold_q | err_now;
      default:   fail_d = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      main_hold_q <= 1'b0;
      sub_hold_q  <= 1'b0;
      result_n    <= 1'b1;
    end else begin
      main_hold_q <= main_hold_d;
      sub_hold_q  <= sub_hold_d;
      result_n    <= ~fail_d;
    end
  end
endmodule

// File: rtl/link_bert.sv
`timescale 1ns/1ps
module link_bert
  import bert_pkg::*;
#(
  parameter int unsigned DATA_W   = BERT_DATA_W,
  parameter int unsigned LFSR_W   = BERT_LFSR_W,
  parameter int unsigned TAP_HI   = BERT_TAP_HI,
  parameter int unsigned TAP_LO   = BERT_TAP_LO,
  parameter int unsigned LOCK_RUN = BERT_LOCK_RUN
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              test_en,
  input  logic              link_sel,
  input  logic              main_force,
  input  logic              latch_en,
  input  logic              gen_en,
  input  logic [DATA_W-1:0] norm_data,
  output logic [DATA_W-1:0] tx_data,
  input  logic [DATA_W-1:0] rx_data,
  output logic              result_n,
  output logic              chk_locked,
  output logic              mode_main,
  output logic              mode_sub
);
  bert_mode_e mode_q;
  logic       test_on;
  logic       gen_run;
  logic       err_now;

  bert_mode_arb u_arb (
    .clk        (clk),
    .rst_n      (rst_n),
    .test_en    (test_en),
    .link_sel   (link_sel),
    .main_force (main_force),
    .mode_q     (mode_q),
    .main_o     (mode_main),
    .sub_o      (mode_sub)
  );

  assign test_on = mode_main | mode_sub;
  assign gen_run = gen_en & test_on;

  bert_pattern_gen #(.DW(DATA_W), .LW(LFSR_W), .TA(TAP_HI), .TB(TAP_LO)) u_gen (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (gen_run),
    .norm_data (norm_data),
    .tx_data   (tx_data)
  );

  bert_pattern_chk #(.DW(DATA_W), .LW(LFSR_W), .TA(TAP_HI), .TB(TAP_LO),
                     .LOCK_RUN(LOCK_RUN)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .active  (test_on),
    .rx_data (rx_data),
    .locked  (chk_locked),
    .err_now (err_now)
  );

  bert_result u_res (
    .clk      (clk),
    .rst_n    (rst_n),
    .mode     (mode_q),
    .latch_en (latch_en),
    .err_now  (err_now),
    .result_n (result_n)
  );
endmodule

// File: rtl/bert_sva.sv
`timescale 1ns/1ps
module bert_sva #(
  parameter int unsigned DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          test_en,
  input logic          main_force,
  input logic          latch_en,
  input logic          mode_main,
  input logic          mode_sub,
  input logic          chk_locked,
  input logic          err_now,
  input logic          gen_run,
  input logic          result_n,
  input logic [DW-1:0] tx_data,
  input logic [DW-1:0] norm_data
);
  AST_PATH_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(mode_main && mode_sub)); // R8

  AST_FORCE_MAIN: assert property (@(posedge clk) disable iff (!rst_n)
    (test_en && main_force) |=> !mode_sub); // R9

  AST_IDLE_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_main && !mode_sub) |=> result_n); // R10

  AST_GEN_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_main && !mode_sub) |-> !gen_run); // R11

  AST_TX_BYPASS: assert property (@(posedge clk) disable iff (!rst_n)
    !gen_run |-> (tx_data == norm_data)); // R1

  AST_HUNT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_main && !chk_locked) |=> result_n); // R4

  AST_LIVE_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_main && !latch_en) |=> (result_n == !$past(err_now))); // R5

  AST_MAIN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_main && latch_en && !result_n && $past(mode_main && latch_en)) |=> !result_n); // R6

  AST_SUB_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_sub && $past(mode_sub) && $past(!result_n)) |-> !result_n); // R7
endmodule

bind link_bert bert_sva #(.DW(DATA_W)) u_bert_sva (
  .clk        (clk),
  .rst_n      (rst_n),
  .test_en    (test_en),
  .main_force (main_force),
  .latch_en   (latch_en),
  .mode_main  (mode_main),
  .mode_sub   (mode_sub),
  .chk_locked (chk_locked),
  .err_now    (err_now),
  .gen_run    (gen_run),
  .result_n   (result_n),
  .tx_data    (tx_data),
  .norm_data  (norm_data)
);

// File: tb/link_bert_bench.sv
`timescale 1ns/1ps
module link_bert_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       test_en, link_sel, main_force, latch_en, gen_en;
  logic [7:0] norm_data, tx_data, rx_data, inj;
  logic       result_n, chk_locked, mode_main, mode_sub;
  int         total = 0;
  int         bad = 0;
  int         wi = 0;
  bit         done = 1'b0;

  always #2 clk = ~clk;

  assign rx_data = tx_data ^ inj;

  link_bert u_link_bert (
    .clk(clk), .rst_n(rst_n), .test_en(test_en), .link_sel(link_sel),
    .main_force(main_force), .latch_en(latch_en), .gen_en(gen_en),
    .norm_data(norm_data), .tx_data(tx_data), .rx_data(rx_data),
    .result_n(result_n), .chk_locked(chk_locked),
    .mode_main(mode_main), .mode_sub(mode_sub)
  );

  // Bit stream b[n] = b[n-7] ^ b[n-6], seven leading ones; word k = bits 8k..8k+7.
  function automatic logic [7:0] ref_word(int k);
    bit b [0:2047];
    logic [7:0] w;
    for (int n = 0; n < 7; n++) b[n] = 1'b1;
    for (int n = 7; n < 8 * k + 15; n++) b[n] = b[n-7] ^ b[n-6];
    for (int j = 0; j < 8; j++) w[7-j] = b[7 + 8 * k + j];
    return w;
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic word(input logic [7:0] e);
    check(tx_data == ref_word(wi), "R2 pattern word", tx_data, ref_word(wi));
    inj = e;
    tick();
    inj = 8'h00;
    wi++;
  endtask

  initial begin
    #800000;
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; test_en = 1'b0; link_sel = 1'b0; main_force = 1'b0;
    latch_en = 1'b0; gen_en = 1'b0; norm_data = 8'h5A; inj = 8'h00;
    repeat (3) tick();
    rst_n = 1'b1;
    tick();

    check(result_n == 1'b1, "R10 reset result", result_n, 1);
    check(!mode_main && !mode_sub, "R8 reset mode", {mode_main, mode_sub}, 0);
    check(chk_locked == 1'b0, "R3 reset unlocked", chk_locked, 0);
    check(tx_data == 8'h5A, "R1 bypass", tx_data, 8'h5A);
    norm_data = 8'hC3;
    #1;
    check(tx_data == 8'hC3, "R1 bypass follows", tx_data, 8'hC3);

    gen_en = 1'b1;
    for (int i = 0; i < 3; i++) begin
      tick();
      check(tx_data == 8'hC3, "R11 gen_en ignored idle", tx_data, 8'hC3);
    end

    // main path, live result
    test_en = 1'b1;
    tick();
    check(mode_main && !mode_sub, "R8 enter main", {mode_main, mode_sub}, 2);
    wi = 0;
    for (int k = 0; k < 40; k++) begin
      word(8'h00);
      if (k == 15) check(chk_locked == 1'b0, "R3 not yet locked", chk_locked, 0);
      if (k == 16) check(chk_locked == 1'b1, "R3 locked", chk_locked, 1);
      check(result_n == 1'b1, "R5 clean stream", result_n, 1);
    end
    for (int b = 0; b < 8; b++) begin
      word(8'h01 << b);
      check(result_n == 1'b0, "R5 live error", result_n, 0);
      word(8'h00);
      check(result_n == 1'b1, "R5 live release", result_n, 1);
    end

    // main path, held result
    latch_en = 1'b1;
    word(8'h00);
    word(8'h01);
    check(result_n == 1'b0, "R6 held error", result_n, 0);
    for (int i = 0; i < 5; i++) begin
      word(8'h00);
      check(result_n == 1'b0, "R6 hold persists", result_n, 0);
    end
    latch_en = 1'b0;
    word(8'h00);
    check(result_n == 1'b1, "R6 cleared by latch_en low", result_n, 1);
    word(8'h00);
    check(result_n == 1'b1, "R6 stays cleared", result_n, 1);

    // leave test mode
    test_en = 1'b0;
    tick();
    tick();
    check(result_n == 1'b1, "R10 idle result", result_n, 1);
    check(!mode_main && !mode_sub, "R10 idle mode", {mode_main, mode_sub}, 0);
    check(chk_locked == 1'b0, "R4 lock dropped", chk_locked, 0);
    check(tx_data == 8'hC3, "R1 bypass after test", tx_data, 8'hC3);

    // re-enter main; error during hunt at word 5 spoils words 5 and 6
    test_en = 1'b1;
    tick();
    wi = 0;
    for (int k = 0; k < 25; k++) begin
      word(k == 5 ? 8'h10 : 8'h00);
      check(result_n == 1'b1, "R4 hunt quiet", result_n, 1);
      if (k == 21) check(chk_locked == 1'b0, "R4 count restarted", chk_locked, 0);
      if (k == 22) check(chk_locked == 1'b1, "R4 lock after restart", chk_locked, 1);
    end

    // direct switch to sub
    link_sel = 1'b1;
    tick();
    check(!mode_main && !mode_sub, "R8 idle gap", {mode_main, mode_sub}, 0);
    tick();
    check(mode_sub && !mode_main, "R8 sub active", {mode_main, mode_sub}, 1);
    wi = 0;
    for (int k = 0; k < 20; k++) begin
      word(8'h00);
      check(result_n == 1'b1, "R7 sub clean", result_n, 1);
    end
    check(chk_locked == 1'b1, "R3 sub locked", chk_locked, 1);
    word(8'h80);
    check(result_n == 1'b0, "R7 sub error", result_n, 0);
    for (int i = 0; i < 4; i++) begin
      word(8'h00);
      check(result_n == 1'b0, "R7 sub hold", result_n, 0);
    end
    latch_en = 1'b1;
    word(8'h00);
    latch_en = 1'b0;
    word(8'h00);
    check(result_n == 1'b0, "R7 latch_en no effect", result_n, 0);

    test_en = 1'b0;
    tick();
    tick();
    check(result_n == 1'b1, "R10 idle after sub", result_n, 1);
    test_en = 1'b1;
    tick();
    tick();
    check(mode_sub == 1'b1, "R7 sub re-entered", mode_sub, 1);
    check(result_n == 1'b0, "R7 hold survives re-entry", result_n, 0);

    // forced main path
    main_force = 1'b1;
    tick();
    tick();
    check(mode_main && !mode_sub, "R9 forced main", {mode_main, mode_sub}, 2);
    for (int i = 0; i < 3; i++) begin
      tick();
      check(!mode_sub, "R9 sub blocked", mode_sub, 0);
      check(result_n == 1'b1, "R9 main fresh result", result_n, 1);
    end

    // only reset clears the sub hold
    main_force = 1'b0;
    rst_n = 1'b0;
    tick();
    rst_n = 1'b1;
    tick();
    check(mode_sub == 1'b1, "R7 sub after reset", mode_sub, 1);
    wi = 0;
    for (int k = 0; k < 20; k++) begin
      word(8'h00);
      check(result_n == 1'b1, "R7 reset cleared hold", result_n, 1);
    end

    test_en = 1'b0;
    tick();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule